// File: doc/BRIEF.md
# Debug Register File with Index Aliasing

This block stores the debug registers of a processor core: four breakpoint address slots, one status word and one control word. A single access port selects a register with a 3-bit index. A read returns the selected word combinationally. A write is applied at the next rising clock edge when the one-cycle write strobe is high. Indices 4 and 5 are legacy names for the status and control words. They work as aliases only while the debug-extensions input is low. While that input is high, an access to either index is refused and an illegal-opcode indication is raised.

The control word is also decoded continuously into per-slot outputs for the breakpoint matching logic: an enable bit, a 2-bit kind and a byte length. A summary flag reports whether any enabled slot is set up as an I/O breakpoint. Every write to the control word forces its fixed-one bit to 1.

Top module: `dbgreg_file`

## Requirements
- R1: After synchronous reset, every address slot reads 0, the status word reads 0xFFFF0FF0, the control word reads 0x00000400, and `io_armed` is 0.
- R2: Indices 0 to 3 select address slots 0 to 3. A write stores `acc_wdata` unchanged, and a later read returns that value.
- R3: Index 6 selects the status word and index 7 selects the control word, whatever the value of `dbg_ext_en`. While `dbg_ext_en` is 0, index 4 reads and writes the status word and index 5 reads and writes the control word.
- R4: While `dbg_ext_en` is 1, a read or write of index 4 or 5 drives `ill_op` high in the same cycle, returns 0 on `acc_rdata`, and changes no register and no decoded output.
- R5: Every control-word write stores the written value with bit 10 forced to 1.
- R6: `slot_en[i]` is 1 exactly when control bit 2i (local enable) or bit 2i+1 (global enable) is 1.
- R7: `slot_type[2i+1:2i]` equals control bits 17+4i:16+4i. Its kind codes are 00 execute, 01 data write, 10 I/O, 11 data read/write. `slot_len[4i+3:4i]` gives the byte length decoded from control bits 19+4i:18+4i, with 00→1, 01→2, 10→8 and 11→4.
- R8: `io_armed` is 1 exactly when some enabled slot has kind 10 (I/O). It takes its new value in the cycle after a control-word write and otherwise holds.
- R9: `ill_op` is 0 unless a read or write is requested to index 4 or 5 while `dbg_ext_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_ext_en | input | 1 | Debug extensions on: indices 4 and 5 fault instead of aliasing |
| acc_idx | input | 3 | Register index for the access |
| acc_rd | input | 1 | Read request this cycle |
| acc_wr | input | 1 | One-cycle write strobe |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data of the selected register, 0 on a refused access |
| ill_op | output | 1 | Illegal-opcode indication for a refused access |
| slot_en | output | 4 | Per-slot enable |
| slot_type | output | 8 | Per-slot 2-bit breakpoint kind |
| slot_len | output | 16 | Per-slot length in bytes, 4 bits each |
| io_armed | output | 1 | Some enabled slot has the I/O kind |

## Verification
The bench builds the block with its default parameters: 32-bit words, four slots, and the status and control words at indices 6 and 7 with aliases at 4 and 5. These are the widths at which the control bit positions for enables, kinds and lengths exist. With four slots, one control word can carry all four length codes and all four kinds at once. That lets a single write show every decode. It also lets the bench show that the I/O summary is armed by either the local or the global enable, and stays clear for a disabled I/O slot.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;

  typedef enum logic [1:0] {
    BKT_EXEC  = 2'b00,
    BKT_WRITE = 2'b01,
    BKT_IO    = 2'b10,
    BKT_RDWR  = 2'b11
  } bkpt_kind_e;

  localparam int LEN_CODE_W = 2;
  localparam int KIND_W     = 2;
  localparam int LEN_OUT_W  = 4;
  localparam int FIELD_W    = KIND_W + LEN_CODE_W;

  // Length code to byte count: the code 2'b10 is the wide (8-byte) case.
  function automatic logic [LEN_OUT_W-1:0] len_bytes(input logic [LEN_CODE_W-1:0] code);
    logic [LEN_OUT_W-1:0] n;
    case (code)
      2'b00:   n = 4'd1;
      2'b01:   n = 4'd2;
      2'b10:   n = 4'd8;
      default: n = 4'd4;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/dbgreg_idx_decode.sv
module dbgreg_idx_decode #(
  parameter int IDX_W        = 3,
  parameter int NUM_SLOTS    = 4,
  parameter int STATUS_IDX   = 6,
  parameter int CTRL_IDX     = 7,
  parameter int STATUS_ALIAS = 4,
  parameter int CTRL_ALIAS   = 5
) (
  input  logic [IDX_W-1:0]     idx,
  input  logic                 ext_en,
  input  logic                 access,
  output logic [NUM_SLOTS-1:0] slot_hit,
  output logic                 status_hit,
  output logic                 ctrl_hit,
  output logic                 fault
);

  logic alias_s;
  logic alias_c;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      slot_hit[i] = (idx == IDX_W'(i));
    end
  end

  assign alias_s    = (idx == IDX_W'(STATUS_ALIAS));
  assign alias_c    = (idx == IDX_W'(CTRL_ALIAS));
  assign status_hit = (idx == IDX_W'(STATUS_IDX)) || (alias_s && !ext_en);
  assign ctrl_hit   = (idx == IDX_W'(CTRL_IDX))   || (alias_c && !ext_en);
  assign fault      = access && ext_en && (alias_s || alias_c);

endmodule

// File: rtl/dbgreg_addr_bank.sv
module dbgreg_addr_bank #(
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SLOTS-1:0]        wr_sel,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [NUM_SLOTS*DATA_W-1:0] addr_flat
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [DATA_W-1:0] addr_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q <= '0;
      end else if (wr_sel[s]) begin
        addr_q <= wr_data;
      end
    end
    assign addr_flat[s*DATA_W +: DATA_W] = addr_q;
  end

endmodule

// File: rtl/dbgreg_ctrl_decode.sv
module dbgreg_ctrl_decode
  import dbgreg_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int EN_W     = 2 * NUM_SLOTS,
  localparam int FLD_W    = FIELD_W * NUM_SLOTS
) (
  input  logic [EN_W-1:0]                enables,
  input  logic [FLD_W-1:0]               fields,
  output logic [NUM_SLOTS-1:0]           slot_en,
  output logic [KIND_W*NUM_SLOTS-1:0]    slot_type,
  output logic [LEN_OUT_W*NUM_SLOTS-1:0] slot_len,
  output logic                           io_armed
);

  logic [NUM_SLOTS-1:0] io_hit;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    bkpt_kind_e kind;
    assign kind       = bkpt_kind_e'(fields[s*FIELD_W +: KIND_W]);
    assign slot_en[s] = enables[2*s] | enables[2*s+1];
    assign slot_type[s*KIND_W +: KIND_W] = kind;
    assign slot_len[s*LEN_OUT_W +: LEN_OUT_W] =
      len_bytes(fields[s*FIELD_W + KIND_W +: LEN_CODE_W]);
    assign io_hit[s]  = slot_en[s] && (kind == BKT_IO);
  end

  assign io_armed = |io_hit;

endmodule

// File: rtl/dbgreg_file.sv
module dbgreg_file
  import dbgreg_pkg::*;
#(
  parameter int          DATA_W       = 32,
  parameter int          NUM_SLOTS    = 4,
  parameter int          IDX_W        = 3,
  parameter int          STATUS_IDX   = 6,
  parameter int          CTRL_IDX     = 7,
  parameter int          STATUS_ALIAS = 4,
  parameter int          CTRL_ALIAS   = 5,
  parameter int          FIELD_BASE   = 16,
  parameter logic [31:0] STATUS_INIT  = 32'hFFFF_0FF0,
  parameter logic [31:0] CTRL_INIT    = 32'h0000_0400,
  parameter logic [31:0] CTRL_ONES    = 32'h0000_0400,
  localparam int EN_W   = 2 * NUM_SLOTS,
  localparam int FLD_W  = FIELD_W * NUM_SLOTS
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           dbg_ext_en,
  input  logic [IDX_W-1:0]               acc_idx,
  input  logic                           acc_rd,
  input  logic                           acc_wr,
  input  logic [DATA_W-1:0]              acc_wdata,
  output logic [DATA_W-1:0]              acc_rdata,
  output logic                           ill_op,
  output logic [NUM_SLOTS-1:0]           slot_en,
  output logic [KIND_W*NUM_SLOTS-1:0]    slot_type,
  output logic [LEN_OUT_W*NUM_SLOTS-1:0] slot_len,
  output logic                           io_armed
);

  logic [NUM_SLOTS-1:0]        slot_hit;
  logic                        status_hit;
  logic                        ctrl_hit;
  logic                        fault;
  logic [NUM_SLOTS*DATA_W-1:0] addr_flat;
  logic [DATA_W-1:0]           status_q;
  logic [DATA_W-1:0]           ctrl_q;
  logic                        wr_ok;

  dbgreg_idx_decode #(
    .IDX_W(IDX_W), .NUM_SLOTS(NUM_SLOTS),
    .STATUS_IDX(STATUS_IDX), .CTRL_IDX(CTRL_IDX),
    .STATUS_ALIAS(STATUS_ALIAS), .CTRL_ALIAS(CTRL_ALIAS)
  ) u_idx (
    .idx(acc_idx), .ext_en(dbg_ext_en), .access(acc_rd | acc_wr),
    .slot_hit(slot_hit), .status_hit(status_hit), .ctrl_hit(ctrl_hit),
    .fault(fault)
  );

  assign wr_ok = acc_wr && !fault;

  dbgreg_addr_bank #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS)) u_bank (
    .clk(clk), .rst(rst),
    .wr_sel(slot_hit & {NUM_SLOTS{wr_ok}}),
    .wr_data(acc_wdata), .addr_flat(addr_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= DATA_W'(STATUS_INIT);
      ctrl_q   <= DATA_W'(CTRL_INIT);
    end else if (wr_ok) begin
      if (status_hit) status_q <= acc_wdata;
      if (ctrl_hit)   ctrl_q   <= acc_wdata | DATA_W'(CTRL_ONES);
    end
  end

  always_comb begin
    acc_rdata = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slot_hit[s]) acc_rdata = addr_flat[s*DATA_W +: DATA_W];
    end
    if (status_hit) acc_rdata = status_q;
    if (ctrl_hit)   acc_rdata = ctrl_q;
    if (fault)      acc_rdata = '0;
  end

  assign ill_op = fault;

  dbgreg_ctrl_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
    .enables(ctrl_q[EN_W-1:0]),
    .fields(ctrl_q[FIELD_BASE +: FLD_W]),
    .slot_en(slot_en), .slot_type(slot_type), .slot_len(slot_len),
    .io_armed(io_armed)
  );

endmodule

// File: rtl/dbgreg_file_chk.sv
module dbgreg_file_chk (
  input logic        clk,
  input logic        rst,
  input logic        dbg_ext_en,
  input logic [2:0]  acc_idx,
  input logic        acc_rd,
  input logic        acc_wr,
  input logic        ill_op,
  input logic        io_armed,
  input logic [31:0] status_q,
  input logic [31:0] ctrl_q
);

  logic legacy_idx;
  logic ctrl_wr_c;
  assign legacy_idx = (acc_idx == 3'd4) || (acc_idx == 3'd5);
  assign ctrl_wr_c  = acc_wr && ((acc_idx == 3'd7) || (acc_idx == 3'd5 && !dbg_ext_en));

  // R4: refused legacy access raises the illegal-opcode indication
  p_legacy_fault_r4: assert property (@(posedge clk) disable iff (rst)
    ((acc_rd || acc_wr) && dbg_ext_en && legacy_idx) |-> ill_op);

  // R9: no indication outside that case
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
    !((acc_rd || acc_wr) && dbg_ext_en && legacy_idx) |-> !ill_op);

  // R4: a refused access leaves status and control untouched
  p_fault_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ill_op |=> ($stable(status_q) && $stable(ctrl_q)));

  // R5: fixed-one bit stays set
  p_fixed_one_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[10]);

  // R8: I/O summary only moves after a control write
  p_io_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl_wr_c) |-> $stable(io_armed));

endmodule

bind dbgreg_file dbgreg_file_chk u_chk (
  .clk(clk), .rst(rst), .dbg_ext_en(dbg_ext_en), .acc_idx(acc_idx),
  .acc_rd(acc_rd), .acc_wr(acc_wr), .ill_op(ill_op), .io_armed(io_armed),
  .status_q(status_q), .ctrl_q(ctrl_q)
);

// File: tb/dbgreg_file_bench.sv
`timescale 1ns/1ps
module dbgreg_file_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dbg_ext_en = 1'b0;
  logic [2:0]  acc_idx = '0;
  logic        acc_rd = 1'b0;
  logic        acc_wr = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        ill_op;
  logic [3:0]  slot_en;
  logic [7:0]  slot_type;
  logic [15:0] slot_len;
  logic        io_armed;

  int checks = 0;
  int errors = 0;
  logic [31:0] got_rd;
  logic        got_ill;

  always #4 clk = ~clk;

  dbgreg_file u_dbgreg_file (
    .clk(clk), .rst(rst), .dbg_ext_en(dbg_ext_en), .acc_idx(acc_idx),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .ill_op(ill_op), .slot_en(slot_en),
    .slot_type(slot_type), .slot_len(slot_len), .io_armed(io_armed)
  );

  typedef struct packed {
    logic        ext;
    logic        wr;
    logic [2:0]  idx;
    logic [31:0] data;
    logic        chk_rd;
    logic [31:0] exp_rd;
    logic        exp_ill;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 3'd0, 32'h0,         1'b1, 32'h0000_0000, 1'b0}, // R1
    '{1'b0, 1'b0, 3'd6, 32'h0,         1'b1, 32'hFFFF_0FF0, 1'b0}, // R1
    '{1'b0, 1'b0, 3'd7, 32'h0,         1'b1, 32'h0000_0400, 1'b0}, // R1
    '{1'b0, 1'b1, 3'd0, 32'h1000_0000, 1'b0, 32'h0,         1'b0}, // R2
    '{1'b0, 1'b1, 3'd3, 32'hDEAD_BEEF, 1'b0, 32'h0,         1'b0}, // R2
    '{1'b0, 1'b0, 3'd0, 32'h0,         1'b1, 32'h1000_0000, 1'b0}, // R2
    '{1'b0, 1'b0, 3'd3, 32'h0,         1'b1, 32'hDEAD_BEEF, 1'b0}, // R2
    '{1'b0, 1'b1, 3'd7, 32'h0,         1'b0, 32'h0,         1'b0}, // R5
    '{1'b0, 1'b0, 3'd7, 32'h0,         1'b1, 32'h0000_0400, 1'b0}, // R5
    '{1'b0, 1'b1, 3'd5, 32'h0000_0003, 1'b0, 32'h0,         1'b0}, // R3
    '{1'b0, 1'b0, 3'd7, 32'h0,         1'b1, 32'h0000_0403, 1'b0}, // R3
    '{1'b0, 1'b1, 3'd4, 32'h1234_5678, 1'b0, 32'h0,         1'b0}, // R3
    '{1'b0, 1'b0, 3'd6, 32'h0,         1'b1, 32'h1234_5678, 1'b0}, // R3
    '{1'b1, 1'b0, 3'd4, 32'h0,         1'b1, 32'h0000_0000, 1'b1}, // R4
    '{1'b1, 1'b1, 3'd4, 32'h0,         1'b0, 32'h0,         1'b1}, // R4
    '{1'b1, 1'b1, 3'd5, 32'h0,         1'b0, 32'h0,         1'b1}, // R4
    '{1'b1, 1'b0, 3'd6, 32'h0,         1'b1, 32'h1234_5678, 1'b0}, // R4
    '{1'b1, 1'b0, 3'd7, 32'h0,         1'b1, 32'h0000_0403, 1'b0}, // R4
    '{1'b0, 1'b0, 3'd5, 32'h0,         1'b1, 32'h0000_0403, 1'b0}, // R3
    '{1'b0, 1'b1, 3'd1, 32'h0000_0055, 1'b0, 32'h0,         1'b0}, // R2
    '{1'b0, 1'b0, 3'd1, 32'h0,         1'b1, 32'h0000_0055, 1'b0}  // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One access: drive after falling edge, sample before the rising edge, release after.
  task automatic access(input logic ext, input logic wr, input logic [2:0] idx,
                        input logic [31:0] data);
    @(negedge clk);
    dbg_ext_en = ext; acc_wr = wr; acc_rd = !wr; acc_idx = idx; acc_wdata = data;
    #2;
    got_rd = acc_rdata; got_ill = ill_op;
    @(posedge clk);
    #1;
    acc_wr = 1'b0; acc_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    chk("R1 io_armed", {31'b0, io_armed}, 32'h0);
    chk("R1 slot_en", {28'b0, slot_en}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      access(VEC[v].ext, VEC[v].wr, VEC[v].idx, VEC[v].data);
      if (VEC[v].chk_rd) chk($sformatf("R2/R3/R4 vec %0d rdata", v), got_rd, VEC[v].exp_rd);
      chk($sformatf("R4/R9 vec %0d ill_op", v), {31'b0, got_ill}, {31'b0, VEC[v].exp_ill});
    end

    // R6 R7 R8: all four length codes and kinds in one control word
    access(1'b0, 1'b1, 3'd7, 32'hCB52_0012);
    #1;
    chk("R6 slot_en", {28'b0, slot_en}, 32'h5);
    chk("R7 slot_type", {24'b0, slot_type}, 32'h36);
    chk("R7 slot_len", {16'b0, slot_len}, 32'h4821);
    chk("R8 io_armed set via global enable", {31'b0, io_armed}, 32'h1);
    access(1'b0, 1'b0, 3'd7, 32'h0);
    chk("R5 control with fixed bit", got_rd, 32'hCB52_0412);

    // R8: I/O kind on a disabled slot does not arm
    access(1'b0, 1'b1, 3'd7, 32'h0002_0000);
    #1;
    chk("R8 io_armed disabled slot", {31'b0, io_armed}, 32'h0);

    // R8: slot 3 I/O via local enable (bit 6), through alias index 5
    access(1'b0, 1'b1, 3'd5, 32'h2000_0040);
    #1;
    chk("R8 io_armed slot3", {31'b0, io_armed}, 32'h1);
    chk("R6 slot_en slot3 local", {28'b0, slot_en}, 32'h8);

    // R4: refused control write leaves decode unchanged
    access(1'b1, 1'b1, 3'd5, 32'h0000_0000);
    chk("R4 ill_op on refused write", {31'b0, got_ill}, 32'h1);
    #1;
    chk("R4 io_armed kept", {31'b0, io_armed}, 32'h1);
    chk("R4 slot_en kept", {28'b0, slot_en}, 32'h8);

    // R9: index 6/7 with extensions on never fault
    access(1'b1, 1'b1, 3'd7, 32'h0000_0000);
    chk("R9 ill_op idx7 ext on", {31'b0, got_ill}, 32'h0);
    #1;
    chk("R8 io_armed cleared", {31'b0, io_armed}, 32'h0);

    // R1: reset again mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    access(1'b0, 1'b0, 3'd3, 32'h0);
    chk("R1 slot3 after reset", got_rd, 32'h0);
    access(1'b0, 1'b0, 3'd6, 32'h0);
    chk("R1 status after reset", got_rd, 32'hFFFF_0FF0);
    access(1'b0, 1'b0, 3'd7, 32'h0);
    chk("R1 control after reset", got_rd, 32'h0000_0400);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule